// File: doc/BRIEF.md
# Burst-Capable Bus Cycle Master

This block runs one external bus cycle at a time for an internal requester. The core offers a request carrying an address, a direction, a burst flag and, for writes, one data word for each beat. The block holds the request and starts the cycle with a one-clock address strobe. It then waits for the external system to complete transfers through one of two active-low ready inputs. The single ready input ends a cycle outright. The burst ready input accepts one beat of a burst and lets the burst go on.

A burst moves `LEN` words (four by default). The word-index bits of the address advance with every accepted beat and wrap inside the aligned line. An active-low last-transfer output tells the external system which beat will close the cycle. The external system may cut a burst short at any beat by returning the single ready. The core receives every captured read word with its beat index. When the cycle ends, the core receives a one-clock done pulse that carries the number of beats moved and whether the burst was cut short.

Top module: `bus_cycle_master`

## Requirements
- R1: After reset, `req_ready` is 1, `bus_ads_n` and `bus_blast_n` are 1, and `done` and `rd_valid` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. For exactly the next clock, `bus_ads_n` is 0, with `bus_addr` equal to the requested address and `bus_wr` equal to `req_write` (1 = write). The block holds the request internally, so later changes on the `req_*` inputs have no effect on the cycle.
- R3: Both ready inputs are ignored while no cycle runs and during the strobe clock. Holding them low at those times neither ends a cycle nor captures data.
- R4: A single (non-burst) cycle ends in the first clock after the strobe clock in which `bus_rdy_n` is 0. On a read, `bus_rdata` in that clock is captured. `bus_brdy_n` has no effect on a single cycle.
- R5: In a burst, each clock after the strobe clock in which `bus_brdy_n` is 0 and `bus_rdy_n` is 1 accepts one beat. Beat b (counted from 0) puts the address out with word-index bits [3:2] set to (start index + b) mod 4, with all other bits unchanged. It drives write slot b, which is `req_wdata[32*b+31:32*b]`. The burst ends on the fourth accepted beat.
- R6: `bus_blast_n` is 0 for the whole of a single cycle, starting from its strobe clock. In a burst it is 0 only while beat 3 is pending, and 1 before that.
- R7: If `bus_rdy_n` is 0 in a burst data clock, `bus_brdy_n` is ignored in that clock. That beat is still captured and the burst ends. `done_aborted` is 1 when this happens before beat 3, and 0 when it happens on beat 3.
- R8: `done` is a one-clock pulse in the clock after the ending clock. In that same clock, `done_beats` gives the number of beats moved and `req_ready` is 1 again.
- R9: On a read, each accepted beat gives a one-clock `rd_valid` in the following clock, with `rd_data` holding the captured word and `rd_index` holding the beat number. On a write, `rd_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core requests a bus cycle |
| req_ready | output | 1 | Block is idle and can take a request |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_burst | input | 1 | 1 = LEN-beat burst, 0 = single transfer |
| req_addr | input | ADDR_W | Start byte address |
| req_wdata | input | LEN*DATA_W | Write words, slot b at bits [DATA_W*b +: DATA_W] |
| rd_valid | output | 1 | A read beat was captured |
| rd_index | output | $clog2(LEN) | Beat number of the captured word |
| rd_data | output | DATA_W | Captured read word |
| done | output | 1 | Cycle finished (one-clock pulse) |
| done_aborted | output | 1 | Burst cut short by the single ready |
| done_beats | output | $clog2(LEN+1) | Beats moved by the finished cycle |
| bus_addr | output | ADDR_W | Address of the pending beat |
| bus_ads_n | output | 1 | Address strobe, active low, strobe clock only |
| bus_wr | output | 1 | Direction of the running cycle |
| bus_wdata | output | DATA_W | Write word of the pending beat |
| bus_rdata | input | DATA_W | Read data from the bus |
| bus_rdy_n | input | 1 | Single ready, active low |
| bus_brdy_n | input | 1 | Burst ready, active low |
| bus_blast_n | output | 1 | Last transfer indicator, active low |

## Verification
The bench builds the block with its default parameters: 32-bit address and data, and a four-beat burst. Four beats are few enough to try every start index with every abort point, from the first beat through the fourth, in both directions. Wait states come from a formula on the start index and the beat number, so every beat position sees zero, one and two waits. Expected addresses, data words, last-transfer levels and done fields are computed arithmetically from the start index and the beat number.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_DATA  = 2'd2
    } bcm_state_e;

endpackage

// File: rtl/bcm_ready_qual.sv
// Turns the two raw active-low ready pins into qualified events.
// The single ready wins over the burst ready in the same clock.
module bcm_ready_qual (
    input  logic in_data,
    input  logic is_burst,
    input  logic rdy_n,
    input  logic brdy_n,
    output logic end_single,
    output logic take_burst
);

    always_comb begin
        end_single = in_data & ~rdy_n;
        take_burst = in_data & is_burst & rdy_n & ~brdy_n;
    end

endmodule

// File: rtl/bcm_beat_ctr.sv
module bcm_beat_ctr #(
    parameter int LEN = 4,
    localparam int BEAT_W = $clog2(LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [BEAT_W-1:0] beat,
    output logic              is_last
);

    logic [BEAT_W-1:0] beat_d, beat_q;

    always_comb begin
        beat_d = beat_q;
        if (clear) begin
            beat_d = '0;
        end else if (step) begin
            beat_d = beat_q + BEAT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign beat    = beat_q;
    assign is_last = (beat_q == BEAT_W'(LEN - 1));

    // A clear must bring the counter back to beat 0 (R5)
    assert_beat_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (beat_q == '0));

endmodule

// File: rtl/bcm_addr_gen.sv
// Places the beat number on the word-index bits, wrapping within the line.
module bcm_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN    = 4,
    localparam int BEAT_W = $clog2(LEN),
    localparam int OFS    = $clog2(DATA_W / 8)
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [BEAT_W-1:0] beat,
    output logic [ADDR_W-1:0] addr
);

    always_comb begin
        addr = base;
        addr[OFS +: BEAT_W] = base[OFS +: BEAT_W] + beat;
    end

endmodule

// File: rtl/bus_cycle_master.sv
module bus_cycle_master #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN    = 4,
    localparam int BEAT_W = $clog2(LEN),
    localparam int CNT_W  = $clog2(LEN + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic                  req_burst,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [LEN*DATA_W-1:0] req_wdata,
    output logic                  rd_valid,
    output logic [BEAT_W-1:0]     rd_index,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  done,
    output logic                  done_aborted,
    output logic [CNT_W-1:0]      done_beats,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic                  bus_ads_n,
    output logic                  bus_wr,
    output logic [DATA_W-1:0]     bus_wdata,
    input  logic [DATA_W-1:0]     bus_rdata,
    input  logic                  bus_rdy_n,
    input  logic                  bus_brdy_n,
    output logic                  bus_blast_n
);
    import bcm_pkg::*;

    typedef struct packed {
        bcm_state_e            st;
        logic                  wr;
        logic                  burst;
        logic [ADDR_W-1:0]     base;
        logic [LEN*DATA_W-1:0] wdata;
        logic                  ads_n;
        logic                  rd_valid;
        logic [BEAT_W-1:0]     rd_index;
        logic [DATA_W-1:0]     rd_data;
        logic                  done;
        logic                  done_aborted;
        logic [CNT_W-1:0]      done_beats;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              accept;
    logic              in_data;
    logic              end_single;
    logic              take_burst;
    logic              beat_taken;
    logic              end_now;
    logic [BEAT_W-1:0] beat;
    logic              is_last;

    assign accept     = (ctl_q.st == ST_IDLE) & req_valid;
    assign in_data    = (ctl_q.st == ST_DATA);
    assign beat_taken = end_single | take_burst;
    assign end_now    = end_single | (take_burst & is_last);

    bcm_ready_qual u_qual (
        .in_data    (in_data),
        .is_burst   (ctl_q.burst),
        .rdy_n      (bus_rdy_n),
        .brdy_n     (bus_brdy_n),
        .end_single (end_single),
        .take_burst (take_burst)
    );

    bcm_beat_ctr #(.LEN(LEN)) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .step    (beat_taken),
        .beat    (beat),
        .is_last (is_last)
    );

    bcm_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN(LEN)) u_addr (
        .base (ctl_q.base),
        .beat (beat),
        .addr (bus_addr)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.ads_n    = 1'b1;
        ctl_d.rd_valid = 1'b0;
        ctl_d.done     = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st    = ST_FIRST;
                    ctl_d.wr    = req_write;
                    ctl_d.burst = req_burst;
                    ctl_d.base  = req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.ads_n = 1'b0;
                end
            end
            ST_FIRST: begin
                ctl_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (beat_taken && !ctl_q.wr) begin
                    ctl_d.rd_valid = 1'b1;
                    ctl_d.rd_data  = bus_rdata;
                    ctl_d.rd_index = beat;
                end
                if (end_now) begin
                    ctl_d.st           = ST_IDLE;
                    ctl_d.done         = 1'b1;
                    ctl_d.done_aborted = ctl_q.burst & end_single & ~is_last;
                    ctl_d.done_beats   = CNT_W'(beat) + CNT_W'(1);
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_IDLE;
            ctl_q.ads_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready    = (ctl_q.st == ST_IDLE);
    assign bus_ads_n    = ctl_q.ads_n;
    assign bus_wr       = ctl_q.wr;
    assign bus_wdata    = ctl_q.wdata[beat*DATA_W +: DATA_W];
    assign bus_blast_n  = ~((ctl_q.st != ST_IDLE) & (~ctl_q.burst | is_last));
    assign rd_valid     = ctl_q.rd_valid;
    assign rd_index     = ctl_q.rd_index;
    assign rd_data      = ctl_q.rd_data;
    assign done         = ctl_q.done;
    assign done_aborted = ctl_q.done_aborted;
    assign done_beats   = ctl_q.done_beats;

    // R2: a taken request leads to the strobe in the next clock
    assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !bus_ads_n);

    // R2: the strobe lasts a single clock
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ads_n |=> bus_ads_n);

    // R3: nothing completes in the strobe clock
    assert_first_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ads_n |=> (!done && !rd_valid));

    // R6: a cycle that ran to completion had last-transfer asserted in its final clock
    assert_blast_before_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_aborted) |-> $past(!bus_blast_n));

    // R7: an aborted burst moved fewer than LEN beats
    assert_abort_short_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_aborted) |-> (done_beats < CNT_W'(LEN)));

    // R8: done is a one-clock pulse and the block is idle with it
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready ##1 !done));

    // R9: no read capture on a write cycle
    assert_no_capture_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !req_ready) |-> !bus_wr);

endmodule

// File: tb/sim_bus_cycle_master.sv
module sim_bus_cycle_master;
    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int LEN = 4;
    localparam int BW  = $clog2(LEN);
    localparam int CW  = $clog2(LEN + 1);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic              req_valid, req_ready, req_write, req_burst;
    logic [AW-1:0]     req_addr;
    logic [LEN*DW-1:0] req_wdata;
    logic              rd_valid;
    logic [BW-1:0]     rd_index;
    logic [DW-1:0]     rd_data;
    logic              done, done_aborted;
    logic [CW-1:0]     done_beats;
    logic [AW-1:0]     bus_addr;
    logic              bus_ads_n, bus_wr, bus_blast_n;
    logic [DW-1:0]     bus_wdata, bus_rdata;
    logic              bus_rdy_n, bus_brdy_n;

    bus_cycle_master #(.ADDR_W(AW), .DATA_W(DW), .LEN(LEN)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_burst(req_burst), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_index(rd_index), .rd_data(rd_data),
        .done(done), .done_aborted(done_aborted), .done_beats(done_beats),
        .bus_addr(bus_addr), .bus_ads_n(bus_ads_n), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy_n(bus_rdy_n),
        .bus_brdy_n(bus_brdy_n), .bus_blast_n(bus_blast_n)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int beat);
        logic [1:0] idx;
        idx = b[3:2] + 2'(beat);
        return {b[AW-1:4], idx, b[1:0]};
    endfunction

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    task automatic run(input bit wr, input bit burst, input int start, input int abort_at, input bit poke_first);
        logic [AW-1:0]     base;
        logic [LEN*DW-1:0] wd;
        int                nb;
        base = 32'h0001_2300 + 32'(start * 4) + (wr ? 32'h1000 : 32'h0) + (burst ? 32'h40 : 32'h0);
        for (int j = 0; j < LEN; j++) wd[j*DW +: DW] = 32'hC000_0000 + 32'(start * 256 + j);
        nb = burst ? ((abort_at >= 0) ? abort_at + 1 : LEN) : 1;

        chk(req_ready == 1'b1, "R8 idle before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_write = wr; req_burst = burst; req_addr = base; req_wdata = wd;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_addr = ~base; req_wdata = ~wd; req_write = ~wr; req_burst = ~burst;
        chk(bus_ads_n == 1'b0, "R2 strobe", 64'(bus_ads_n), 64'd0);
        chk(bus_addr == base, "R2 address", 64'(bus_addr), 64'(base));
        chk(bus_wr == wr, "R2 direction", 64'(bus_wr), 64'(wr));
        chk(bus_blast_n == burst, "R6 last in strobe clock", 64'(bus_blast_n), 64'(burst));
        if (poke_first) begin bus_rdy_n = 1'b0; bus_brdy_n = 1'b0; bus_rdata = 32'hDEAD_BEEF; end
        @(posedge clk); @(negedge clk);
        bus_rdy_n = 1'b1; bus_brdy_n = 1'b1;
        chk(done == 1'b0 && rd_valid == 1'b0, "R3 strobe clock ignored", {done, rd_valid}, 64'd0);
        chk(bus_ads_n == 1'b1, "R2 strobe one clock", 64'(bus_ads_n), 64'd1);

        for (int b = 0; b < nb; b++) begin
            int w;
            logic exp_bl;
            w = (start + b) % 3;
            exp_bl = burst ? (b != LEN - 1) : 1'b0;
            for (int k = 0; k < w; k++) begin
                if (!burst) bus_brdy_n = 1'b0;
                chk(bus_addr == exp_addr(base, b), "R5 address in wait", 64'(bus_addr), 64'(exp_addr(base, b)));
                @(posedge clk); @(negedge clk);
                bus_brdy_n = 1'b1;
                chk(done == 1'b0 && rd_valid == 1'b0, burst ? "R5 wait state" : "R4 burst ready ignored on single",
                    {done, rd_valid}, 64'd0);
            end
            bus_rdata = mem_word(exp_addr(base, b));
            chk(bus_addr == exp_addr(base, b), "R5 beat address", 64'(bus_addr), 64'(exp_addr(base, b)));
            chk(bus_blast_n == exp_bl, "R6 last level", 64'(bus_blast_n), 64'(exp_bl));
            if (wr) chk(bus_wdata == wd[b*DW +: DW], "R5 write slot", 64'(bus_wdata), 64'(wd[b*DW +: DW]));
            if (!burst) bus_rdy_n = 1'b0;
            else if (b == abort_at) begin bus_rdy_n = 1'b0; bus_brdy_n = 1'b0; end
            else bus_brdy_n = 1'b0;
            @(posedge clk); @(negedge clk);
            bus_rdy_n = 1'b1; bus_brdy_n = 1'b1; bus_rdata = '0;
            if (!wr) begin
                chk(rd_valid == 1'b1, "R9 capture strobe", 64'(rd_valid), 64'd1);
                chk(rd_data == mem_word(exp_addr(base, b)), "R5 capture order", 64'(rd_data), 64'(mem_word(exp_addr(base, b))));
                chk(rd_index == BW'(b), "R9 beat index", 64'(rd_index), 64'(b));
            end else begin
                chk(rd_valid == 1'b0, "R9 no capture on write", 64'(rd_valid), 64'd0);
            end
            chk(done == (b == nb - 1), burst ? "R7 R8 done timing" : "R4 single end", 64'(done), 64'(b == nb - 1));
            if (b == nb - 1) begin
                logic exp_ab;
                exp_ab = burst && (abort_at >= 0) && (abort_at < LEN - 1);
                chk(done_beats == CW'(nb), "R8 beat count", 64'(done_beats), 64'(nb));
                chk(done_aborted == exp_ab, "R7 abort flag", 64'(done_aborted), 64'(exp_ab));
                chk(req_ready == 1'b1, "R8 ready with done", 64'(req_ready), 64'd1);
            end
        end
        @(posedge clk); @(negedge clk);
        chk(done == 1'b0 && rd_valid == 1'b0, "R8 done one clock", {done, rd_valid}, 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_burst = 1'b0;
        req_addr = '0; req_wdata = '0; bus_rdata = '0; bus_rdy_n = 1'b1; bus_brdy_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
        chk(bus_ads_n == 1'b1 && bus_blast_n == 1'b1, "R1 bus idle", {bus_ads_n, bus_blast_n}, 64'd3);
        chk(done == 1'b0 && rd_valid == 1'b0, "R1 core outputs", {done, rd_valid}, 64'd0);

        bus_rdy_n = 1'b0; bus_brdy_n = 1'b0;
        repeat (3) begin
            @(posedge clk); @(negedge clk);
            chk(done == 1'b0 && rd_valid == 1'b0 && req_ready == 1'b1, "R3 idle readies ignored",
                {done, rd_valid, req_ready}, 64'd1);
        end
        bus_rdy_n = 1'b1; bus_brdy_n = 1'b1;

        for (int wr = 0; wr < 2; wr++)
            for (int s = 0; s < LEN; s++)
                run(wr[0], 1'b0, s, -1, s[0]);
        for (int wr = 0; wr < 2; wr++)
            for (int s = 0; s < LEN; s++)
                for (int ab = -1; ab < LEN; ab++)
                    run(wr[0], 1'b1, s, ab, ab[0] ^ s[0]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule